// File: doc/BRIEF.md
# SPI Transmit/Receive Byte Buffer with Watermarks

This block sits between a register interface and a serial shift engine and buffers bytes in both directions. The register side pushes bytes for transmission and pops received bytes. The shift engine pops transmit bytes and pushes received ones. Each direction has its own queue. Software sets a mode input to choose between a queue of `DEPTH` entries and a single holding register per direction.

In queue mode the block raises a receive near-full flag and a transmit near-empty flag. A select input sets the level for each flag. Software can use these flags to move bursts of bytes at a time, and it empties the receive side while the receive-empty flag is low. In single-register mode only a transmit-empty flag and a receive-full flag are meaningful. Two interrupt requests are produced, each gated by its own enable. A 16-bit status word packs the basic flags in its low byte and the queue flags in its high byte. When the enable input is low, the block returns to its empty state.

Top module: `spi_fifo_buf`

## Requirements
- R1: While `enable_i` is low at a rising clock edge, both queues are emptied, both overflow bits and both data outputs are cleared, and pushes and pops taken at that edge have no effect. An active-low asynchronous reset gives the same state.
- R2: Bytes leave each queue in the order they entered. A popped byte appears on the queue's data output after the rising edge that accepts the pop, and it is held until the next accepted pop.
- R3: A push into a full queue is dropped, and it sets that direction's overflow bit. The bit stays set until R1 clears it.
- R4: A pop from an empty queue leaves the data output and the fill level unchanged.
- R5: In queue mode, `rx_near_full_o` is high when the receive level is at least 3/4 of `DEPTH` if `rx_mark_sel_i`=0, and at least 1/2 of `DEPTH` if it is 1. Outside queue mode it is low.
- R6: In queue mode, `tx_near_empty_o` is high when the transmit level is at most 1/2 of `DEPTH` if `tx_mark_sel_i`=0, and at most 1/4 of `DEPTH` if it is 1. Outside queue mode it is low.
- R7: `rx_fifo_empty_o` is high exactly when the receive level is zero.
- R8: With `fifo_mode_i`=0, each direction holds one byte: a queue counts as full at a level of 1 or more. `tx_empty_o` is high when the transmit level is zero, and `rx_full_o` is high when the receive queue is full.
- R9: `rx_irq_o` = `rx_ie_i` AND (`rx_near_full_o` in queue mode, `rx_full_o` otherwise). `tx_irq_o` = `tx_ie_i` AND (`tx_near_empty_o` in queue mode, `tx_empty_o` otherwise).
- R10: `status_o` bits: 0 receive full, 1 transmit empty, 2 receive overflow, 3 transmit overflow, 8 receive empty, 9 transmit full, 10 receive near-full, 11 transmit near-empty. All other bits are 0.
- R11: A push and a pop at the same edge on a non-empty, non-full queue are both accepted and leave the level unchanged. On an empty queue only the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable; low clears all state |
| fifo_mode_i | input | 1 | 1 = queue mode, 0 = single register |
| rx_mark_sel_i | input | 1 | Receive mark: 0 = 3/4, 1 = 1/2 |
| tx_mark_sel_i | input | 1 | Transmit mark: 0 = 1/2, 1 = 1/4 |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| tx_push_i | input | 1 | Register side pushes a transmit byte |
| tx_wdata_i | input | DW | Transmit byte |
| rx_pop_i | input | 1 | Register side pops a receive byte |
| rx_rdata_o | output | DW | Last popped receive byte |
| eng_tx_pop_i | input | 1 | Engine pops a transmit byte |
| eng_tx_data_o | output | DW | Last popped transmit byte |
| eng_rx_push_i | input | 1 | Engine pushes a receive byte |
| eng_rx_data_i | input | DW | Received byte |
| tx_empty_o | output | 1 | Transmit level is zero |
| rx_full_o | output | 1 | Receive queue full |
| rx_fifo_empty_o | output | 1 | Receive level is zero |
| rx_near_full_o | output | 1 | Receive watermark reached |
| tx_near_empty_o | output | 1 | Transmit watermark reached |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_irq_o | output | 1 | Transmit interrupt request |
| status_o | output | 16 | Packed status word |

## Verification
The fill levels, overflow bits and data holding registers change only on a rising edge. The flags, interrupts and status word are combinational from those registers and the configuration inputs, so every result is due right after the edge that takes the stimulus. The bench changes inputs at the falling edge and updates its queue model at the rising edge. It compares every output at the next falling edge, exactly one edge after each stimulus. Random traffic with mode and enable changes runs after the directed cases for full, empty, simultaneous, underflow and disable.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef struct packed {
    logic [3:0] rsvd;
    logic       tx_ovf;
    logic       rx_ovf;
    logic       tx_empty;
    logic       rx_full;
  } base_stat_t;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       tx_near_empty;
    logic       rx_near_full;
    logic       tx_full;
    logic       rx_empty;
  } fifo_stat_t;
endpackage

// File: rtl/spi_fifo_store.sv
module spi_fifo_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_nxt, rd_nxt;
  logic [LW-1:0] level_q, cap;
  logic [DW-1:0] data_q;
  logic          ovf_q, push_ok, pop_ok;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_q + AW'(1);
      assign rd_nxt = rd_q + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      assign rd_nxt = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    end
  endgenerate

  assign cap     = single_i ? LW'(1) : LW'(DEPTH);
  assign full_o  = level_q >= cap;
  assign empty_o = level_q == '0;
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0; data_q <= '0; ovf_q <= 1'b0;
    end else if (clear_i) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0; data_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_nxt;
      if (pop_ok) begin
        rd_q   <= rd_nxt;
        data_q <= mem_q[rd_q];
      end
      level_q <= level_q + LW'(push_ok) - LW'(pop_ok);
      ovf_q   <= ovf_q | (push_i & full_o);
    end
  end

  assign data_o  = data_q;
  assign level_o = level_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/spi_fifo_marks.sv
module spi_fifo_marks #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          fifo_mode_i,
  input  logic          rx_sel_i,
  input  logic          tx_sel_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] tx_level_i,
  output logic          rx_near_full_o,
  output logic          tx_near_empty_o
);
  localparam logic [LW-1:0] RX_HI  = LW'((3 * DEPTH) / 4);
  localparam logic [LW-1:0] RX_MID = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TX_MID = LW'(DEPTH / 2);
  localparam logic [LW-1:0] TX_LO  = LW'(DEPTH / 4);

  logic [LW-1:0] rx_mark, tx_mark;
  assign rx_mark = rx_sel_i ? RX_MID : RX_HI;
  assign tx_mark = tx_sel_i ? TX_LO : TX_MID;

  assign rx_near_full_o  = fifo_mode_i & (rx_level_i >= rx_mark);
  assign tx_near_empty_o = fifo_mode_i & (tx_level_i <= tx_mark);
endmodule

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          fifo_mode_i,
  input  logic          rx_mark_sel_i,
  input  logic          tx_mark_sel_i,
  input  logic          rx_ie_i,
  input  logic          tx_ie_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_wdata_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_rdata_o,
  input  logic          eng_tx_pop_i,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  output logic          tx_empty_o,
  output logic          rx_full_o,
  output logic          rx_fifo_empty_o,
  output logic          rx_near_full_o,
  output logic          tx_near_empty_o,
  output logic          rx_ovf_o,
  output logic          tx_ovf_o,
  output logic          rx_irq_o,
  output logic          tx_irq_o,
  output logic [15:0]   status_o
);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, rx_empty, clear, single;
  base_stat_t    base_st;
  fifo_stat_t    fifo_st;

  assign clear  = ~enable_i;
  assign single = ~fifo_mode_i;

  spi_fifo_store #(.DEPTH(DEPTH), .DW(DW)) i_tx_store (
    .clk_i, .rst_ni, .clear_i(clear), .single_i(single),
    .push_i(tx_push_i), .data_i(tx_wdata_i), .pop_i(eng_tx_pop_i),
    .data_o(eng_tx_data_o), .level_o(tx_level), .empty_o(tx_empty_o),
    .full_o(tx_full), .ovf_o(tx_ovf_o)
  );

  spi_fifo_store #(.DEPTH(DEPTH), .DW(DW)) i_rx_store (
    .clk_i, .rst_ni, .clear_i(clear), .single_i(single),
    .push_i(eng_rx_push_i), .data_i(eng_rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_rdata_o), .level_o(rx_level), .empty_o(rx_empty),
    .full_o(rx_full_o), .ovf_o(rx_ovf_o)
  );

  spi_fifo_marks #(.DEPTH(DEPTH)) i_marks (
    .fifo_mode_i, .rx_sel_i(rx_mark_sel_i), .tx_sel_i(tx_mark_sel_i),
    .rx_level_i(rx_level), .tx_level_i(tx_level),
    .rx_near_full_o, .tx_near_empty_o
  );

  assign rx_fifo_empty_o = rx_empty;

  assign rx_irq_o = rx_ie_i & (fifo_mode_i ? rx_near_full_o : rx_full_o);
  assign tx_irq_o = tx_ie_i & (fifo_mode_i ? tx_near_empty_o : tx_empty_o);

  always_comb begin
    base_st          = '0;
    base_st.rx_full  = rx_full_o;
    base_st.tx_empty = tx_empty_o;
    base_st.rx_ovf   = rx_ovf_o;
    base_st.tx_ovf   = tx_ovf_o;
    fifo_st               = '0;
    fifo_st.rx_empty      = rx_empty;
    fifo_st.tx_full       = tx_full;
    fifo_st.rx_near_full  = rx_near_full_o;
    fifo_st.tx_near_empty = tx_near_empty_o;
  end

  assign status_o = {fifo_st, base_st};
endmodule

// File: rtl/spi_fifo_buf_chk.sv
module spi_fifo_buf_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic          fifo_mode_i,
  input logic          rx_ie_i,
  input logic          tx_ie_i,
  input logic          rx_pop_i,
  input logic [DW-1:0] rx_rdata_o,
  input logic          eng_rx_push_i,
  input logic          tx_empty_o,
  input logic          rx_full_o,
  input logic          rx_fifo_empty_o,
  input logic          rx_near_full_o,
  input logic          tx_near_empty_o,
  input logic          rx_ovf_o,
  input logic          tx_ovf_o,
  input logic          rx_irq_o,
  input logic          tx_irq_o
);
  p_disable_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (rx_fifo_empty_o && tx_empty_o && !rx_ovf_o && !tx_ovf_o));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && eng_rx_push_i && rx_full_o) |=> rx_ovf_o);

  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && rx_ovf_o) |=> rx_ovf_o);

  p_underflow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && rx_pop_i && rx_fifo_empty_o) |=> $stable(rx_rdata_o));

  p_single_no_marks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_mode_i |-> (!rx_near_full_o && !tx_near_empty_o));

  p_empty_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fifo_empty_o |-> !rx_full_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ie_i |-> !rx_irq_o) and (!tx_ie_i |-> !tx_irq_o));
endmodule

bind spi_fifo_buf spi_fifo_buf_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_spi_fifo_buf.sv
module test_spi_fifo_buf;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic enable = 1'b0, fifo_mode = 1'b1, rx_sel = 1'b0, tx_sel = 1'b0, rx_ie = 1'b0, tx_ie = 1'b0;
  logic tx_push = 1'b0, rx_pop = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic [7:0] tx_wdata = '0, eng_rdata = '0;
  logic [7:0] rx_rdata, eng_tx_data;
  logic tx_empty, rx_full, rx_fempty, rx_nf, tx_ne, rx_ovf, tx_ovf, rx_irq, tx_irq;
  logic [15:0] status;

  always #10 clk = ~clk;

  spi_fifo_buf i_spi_fifo_buf (
    .clk_i(clk), .rst_ni, .enable_i(enable), .fifo_mode_i(fifo_mode),
    .rx_mark_sel_i(rx_sel), .tx_mark_sel_i(tx_sel), .rx_ie_i(rx_ie), .tx_ie_i(tx_ie),
    .tx_push_i(tx_push), .tx_wdata_i(tx_wdata), .rx_pop_i(rx_pop), .rx_rdata_o(rx_rdata),
    .eng_tx_pop_i(eng_pop), .eng_tx_data_o(eng_tx_data),
    .eng_rx_push_i(eng_push), .eng_rx_data_i(eng_rdata),
    .tx_empty_o(tx_empty), .rx_full_o(rx_full), .rx_fifo_empty_o(rx_fempty),
    .rx_near_full_o(rx_nf), .tx_near_empty_o(tx_ne), .rx_ovf_o(rx_ovf), .tx_ovf_o(tx_ovf),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .status_o(status)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] m_tx_dout = '0, m_rx_dout = '0;
  bit m_tx_ovf = 0, m_rx_ovf = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int cap();
    return fifo_mode ? DEPTH : 1;
  endfunction

  task automatic model_edge();
    bit tfull, rfull, tpop, tpsh, rpop, rpsh;
    if (!rst_ni || !enable) begin
      txq.delete(); rxq.delete();
      m_tx_dout = '0; m_rx_dout = '0; m_tx_ovf = 0; m_rx_ovf = 0;
      return;
    end
    tfull = txq.size() >= cap();
    rfull = rxq.size() >= cap();
    tpop = eng_pop && txq.size() > 0;
    tpsh = tx_push && !tfull;
    rpop = rx_pop && rxq.size() > 0;
    rpsh = eng_push && !rfull;
    if (tx_push && tfull) m_tx_ovf = 1;
    if (eng_push && rfull) m_rx_ovf = 1;
    if (tpop) m_tx_dout = txq.pop_front();
    if (tpsh) txq.push_back(tx_wdata);
    if (rpop) m_rx_dout = rxq.pop_front();
    if (rpsh) rxq.push_back(eng_rdata);
  endtask

  task automatic compare();
    bit e_rfull, e_tempty, e_tfull, e_nf, e_ne, e_rirq, e_tirq;
    logic [15:0] e_st;
    e_rfull  = rxq.size() >= cap();
    e_tfull  = txq.size() >= cap();
    e_tempty = txq.size() == 0;
    e_nf = fifo_mode && (rxq.size() >= (rx_sel ? DEPTH/2 : (3*DEPTH)/4));
    e_ne = fifo_mode && (txq.size() <= (tx_sel ? DEPTH/4 : DEPTH/2));
    e_rirq = rx_ie && (fifo_mode ? e_nf : e_rfull);
    e_tirq = tx_ie && (fifo_mode ? e_ne : e_tempty);
    e_st = {4'b0, e_ne, e_nf, e_tfull, rxq.size() == 0, 4'b0, m_tx_ovf, m_rx_ovf, e_tempty, e_rfull};
    chk("R2", "rx_rdata", rx_rdata, m_rx_dout);
    chk("R2", "eng_tx_data", eng_tx_data, m_tx_dout);
    chk("R3", "rx_ovf", rx_ovf, m_rx_ovf);
    chk("R3", "tx_ovf", tx_ovf, m_tx_ovf);
    chk("R5", "rx_near_full", rx_nf, e_nf);
    chk("R6", "tx_near_empty", tx_ne, e_ne);
    chk("R7", "rx_fifo_empty", rx_fempty, rxq.size() == 0);
    chk("R8", "tx_empty", tx_empty, e_tempty);
    chk("R8", "rx_full", rx_full, e_rfull);
    chk("R9", "rx_irq", rx_irq, e_rirq);
    chk("R9", "tx_irq", tx_irq, e_tirq);
    chk("R10", "status", status, e_st);
  endtask

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit tp, input [7:0] td, input bit ep, input bit erp,
                      input [7:0] erd, input bit rp);
    tx_push = tp; tx_wdata = td; eng_pop = ep; eng_push = erp; eng_rdata = erd; rx_pop = rp;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    tx_push = 0; eng_pop = 0; eng_push = 0; rx_pop = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    @(negedge clk);
    compare();                      // R1 reset state
    chk("R1", "status_reset", status, 16'h0902);
    rst_ni = 1'b1;
    step(1, 8'hAA, 0, 1, 8'h55, 0); // disabled: ignored
    chk("R1", "rx_fifo_empty_disabled", rx_fempty, 1);
    enable = 1'b1;
    step(0, 0, 0, 0, 0, 0);

    // tx fill past full, R3
    for (int i = 0; i < DEPTH + 2; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0);
    chk("R3", "tx_ovf_after_fill", tx_ovf, 1);
    tx_sel = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, 0);
    chk("R2", "last_tx_byte", eng_tx_data, 8'h17);
    held = eng_tx_data;
    step(0, 0, 1, 0, 0, 0);         // R4 underflow
    chk("R4", "tx_underflow_hold", eng_tx_data, held);

    // rx fill with both marks, R5
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 5) rx_sel = 1'b1;
      step(0, 0, 0, 1, 8'h80 + 8'(i), 0);
    end
    rx_ie = 1'b1; tx_ie = 1'b1;
    rx_sel = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    // R11: simultaneous on full: push dropped, pop accepted
    step(0, 0, 0, 1, 8'hEE, 1);
    chk("R11", "rx_pop_while_full", rx_rdata, 8'h80);
    step(0, 0, 0, 1, 8'hE1, 1);     // R11 mid-level both accepted
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 0, 0, 1);
    held = rx_rdata;
    step(0, 0, 0, 1, 8'h42, 1);     // R11 empty: only push accepted
    chk("R11", "rx_empty_simul", rx_rdata, held);
    chk("R11", "rx_level_one", rx_fempty, 0);
    step(0, 0, 0, 0, 0, 1);
    chk("R4", "rx_last_pop", rx_rdata, 8'h42);

    // disable clears, R1
    step(1, 8'h01, 0, 1, 8'h02, 0);
    enable = 1'b0;
    step(1, 8'h03, 0, 1, 8'h04, 0);
    chk("R1", "cleared_ovf", rx_ovf, 0);
    chk("R1", "cleared_tx", tx_empty, 1);
    enable = 1'b1;

    // single-register mode, R8
    fifo_mode = 1'b0;
    step(0, 0, 0, 1, 8'h61, 0);
    chk("R8", "single_rx_full", rx_full, 1);
    step(0, 0, 0, 1, 8'h62, 0);
    chk("R8", "single_rx_ovf", rx_ovf, 1);
    step(1, 8'h71, 0, 0, 0, 0);
    chk("R8", "single_tx_not_empty", tx_empty, 0);
    step(1, 8'h72, 1, 0, 0, 1);
    chk("R8", "single_rx_byte", rx_rdata, 8'h61);
    chk("R8", "single_tx_byte", eng_tx_data, 8'h71);
    rx_ie = 1'b0;
    step(0, 0, 0, 0, 0, 0);

    // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        fifo_mode = 1'($urandom); rx_sel = 1'($urandom); tx_sel = 1'($urandom);
        rx_ie = 1'($urandom); tx_ie = 1'($urandom);
      end
      enable = ($urandom_range(0, 63) != 0);
      step(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule